// File: doc/BRIEF.md
# VBI Sample Output Formatter

This block takes raw vertical-blanking-interval samples, one byte per cycle with a valid qualifier, and places them on a 16-bit video pixel port. The port can run as a full 16-bit word lane, where two samples share one word, or as an 8-bit lane, where each sample goes out alone on the upper byte. An ordering bit chooses the byte placement or byte sequence. This lets a downstream capture engine receive samples in the order its packing logic expects.

When range limiting is enabled, every sample byte is clamped so that the codes reserved for embedded timing never appear on the bus. When the upstream front end reports that no video is present, incoming samples are discarded. In their place the block emits a flat blue YCrCb field, one output for each valid input cycle, so the display path still sees a well-formed picture.

A line-end marker travels with the last sample of each line. An unpaired final sample is flushed at that point instead of waiting for a partner that will never arrive.

Top module: `vbi_fmt_top`

## Requirements
- R1: Word lane (mode_8b=0) with order_nat=0: for samples n and n+1, one word {n, n+1} is emitted, with n on out_data[15:8] and n+1 on out_data[7:0].
- R2: Word lane with order_nat=1: each pair is emitted as {n+1, n}, with n on out_data[7:0].
- R3: Byte lane (mode_8b=1) with order_nat=0: bytes leave in pair-swapped order n+1, n, n+3, n+2, and so on. Each byte is on out_data[15:8] and out_data[7:0] is 0x00.
- R4: Byte lane with order_nat=1: bytes leave in arrival order on out_data[15:8], one cycle after the input edge, with out_data[7:0] at 0x00.
- R5: With limit_en=1, a VBI sample of 0x00 is output as 0x01 and a sample of 0xFF as 0xFE. Other values pass unchanged. With limit_en=0, every value passes unchanged.
- R6: With video_present=0, in_sample is ignored and each valid input cycle yields one blue-field output with out_is_vbi=0. In the byte lane the upper byte cycles through 0xF0, 0x29, 0x6E, 0x29. In the word lane the words alternate 0x29F0 and 0x296E. The sequence restarts at its first entry whenever video_present is high at a clock edge.
- R7: A sample marked with in_last that has no partner is flushed. In the byte lane it goes out alone, after any byte still pending. In the word lane it is padded with 0x80 in the partner's byte: {s, 0x80} for order_nat=0 and {0x80, s} for order_nat=1.
- R8: out_valid is high for exactly one cycle per output byte or word, and out_data holds its value while out_valid is low.
- R9: After reset, out_valid and out_data are 0.
- R10: out_is_vbi is 1 on every output carrying sample data and 0 on every blue-field output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | 8 | Raw VBI sample |
| in_last | input | 1 | Marks the last sample of a line |
| mode_8b | input | 1 | 1 = byte lane, 0 = word lane |
| order_nat | input | 1 | Ordering bit (see R1 to R4) |
| limit_en | input | 1 | Clamp samples to 0x01..0xFE |
| video_present | input | 1 | Upstream video detected |
| out_data | output | 16 | Pixel port data |
| out_valid | output | 1 | One-cycle strobe per output |
| out_is_vbi | output | 1 | 1 = sample data, 0 = blue field |

## Verification
The hardest case to reach is the byte-lane swap with back-to-back samples. In that case a pending byte is still being emitted while the next pair starts. An odd last sample can also arrive in the very cycle the pending byte leaves. The stimulus therefore mixes gap-free bursts with random idle gaps and random line lengths, including odd ones. Directed lines of one to three samples and lines of only 0x00 and 0xFF target the flush and clamp corners.

// File: rtl/vbi_fmt_pkg.sv
package vbi_fmt_pkg;
  localparam logic [7:0] BLUE_CB = 8'hF0;
  localparam logic [7:0] BLUE_Y  = 8'h29;
  localparam logic [7:0] BLUE_CR = 8'h6E;
endpackage

// File: rtl/vbi_limit.sv
module vbi_limit #(
  parameter int unsigned SW = 8
) (
  input  logic          en,
  input  logic [SW-1:0] d,
  output logic [SW-1:0] q
);
  localparam logic [SW-1:0] LO_CODE = '0;
  localparam logic [SW-1:0] HI_CODE = '1;

  always_comb begin
    q = d;
    if (en && d == LO_CODE) q = LO_CODE + 1'b1;
    if (en && d == HI_CODE) q = HI_CODE - 1'b1;
  end
endmodule

// File: rtl/vbi_blue_gen.sv
module vbi_blue_gen #(
  parameter int unsigned SW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  output logic [SW-1:0]   blue_byte,
  output logic [2*SW-1:0] blue_word
);
  import vbi_fmt_pkg::*;
  localparam int unsigned SH = SW - 8;

  logic [1:0] phase, phase_nx;

  always_comb begin
    phase_nx = phase;
    if (clr)      phase_nx = 2'd0;
    else if (adv) phase_nx = phase + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= 2'd0;
    else        phase <= phase_nx;
  end

  logic [SW-1:0] cb_w, y_w, cr_w;
  assign cb_w = SW'(BLUE_CB) << SH;
  assign y_w  = SW'(BLUE_Y)  << SH;
  assign cr_w = SW'(BLUE_CR) << SH;

  always_comb begin
    unique case (phase)
      2'd0:    blue_byte = cb_w;
      2'd2:    blue_byte = cr_w;
      default: blue_byte = y_w;
    endcase
    blue_word = {y_w, phase[0] ? cr_w : cb_w};
  end
endmodule

// File: rtl/vbi_order_core.sv
module vbi_order_core #(
  parameter int unsigned SW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_8b,
  input  logic            order_nat,
  input  logic            video,
  input  logic            s_valid,
  input  logic [SW-1:0]   s_data,
  input  logic            s_last,
  input  logic [SW-1:0]   blue_byte,
  input  logic [2*SW-1:0] blue_word,
  output logic [2*SW-1:0] o_data,
  output logic            o_valid,
  output logic            o_vbi
);
  localparam logic [SW-1:0] ZB  = '0;
  localparam logic [SW-1:0] PAD = SW'(1) << (SW - 1);

  logic            hold_v, hold_v_nx, pend_v, pend_v_nx;
  logic [SW-1:0]   hold_d, hold_d_nx, pend_d, pend_d_nx;
  logic [2*SW-1:0] o_data_nx;
  logic            o_valid_nx, o_vbi_nx;

  always_comb begin
    hold_v_nx  = hold_v;
    hold_d_nx  = hold_d;
    pend_v_nx  = pend_v;
    pend_d_nx  = pend_d;
    o_data_nx  = o_data;
    o_valid_nx = 1'b0;
    o_vbi_nx   = o_vbi;
    if (!video) begin
      hold_v_nx = 1'b0;
      pend_v_nx = 1'b0;
      if (s_valid) begin
        o_valid_nx = 1'b1;
        o_vbi_nx   = 1'b0;
        o_data_nx  = mode_8b ? {blue_byte, ZB} : blue_word;
      end
    end else begin
      if (pend_v) begin
        o_valid_nx = 1'b1;
        o_vbi_nx   = 1'b1;
        o_data_nx  = {pend_d, ZB};
        pend_v_nx  = 1'b0;
      end
      if (s_valid) begin
        if (mode_8b && order_nat) begin
          o_valid_nx = 1'b1;
          o_vbi_nx   = 1'b1;
          o_data_nx  = {s_data, ZB};
        end else if (!hold_v) begin
          if (!s_last) begin
            hold_v_nx = 1'b1;
            hold_d_nx = s_data;
          end else if (mode_8b) begin
            if (pend_v) begin
              pend_v_nx = 1'b1;
              pend_d_nx = s_data;
            end else begin
              o_valid_nx = 1'b1;
              o_vbi_nx   = 1'b1;
              o_data_nx  = {s_data, ZB};
            end
          end else begin
            o_valid_nx = 1'b1;
            o_vbi_nx   = 1'b1;
            o_data_nx  = order_nat ? {PAD, s_data} : {s_data, PAD};
          end
        end else begin
          hold_v_nx  = 1'b0;
          o_valid_nx = 1'b1;
          o_vbi_nx   = 1'b1;
          if (mode_8b) begin
            o_data_nx = {s_data, ZB};
            pend_v_nx = 1'b1;
            pend_d_nx = hold_d;
          end else begin
            o_data_nx = order_nat ? {s_data, hold_d} : {hold_d, s_data};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v  <= 1'b0;
      hold_d  <= '0;
      pend_v  <= 1'b0;
      pend_d  <= '0;
      o_data  <= '0;
      o_valid <= 1'b0;
      o_vbi   <= 1'b0;
    end else begin
      hold_v  <= hold_v_nx;
      hold_d  <= hold_d_nx;
      pend_v  <= pend_v_nx;
      pend_d  <= pend_d_nx;
      o_data  <= o_data_nx;
      o_valid <= o_valid_nx;
      o_vbi   <= o_vbi_nx;
    end
  end
endmodule

// File: rtl/vbi_fmt_top.sv
module vbi_fmt_top #(
  parameter int unsigned SW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [SW-1:0]   in_sample,
  input  logic            in_last,
  input  logic            mode_8b,
  input  logic            order_nat,
  input  logic            limit_en,
  input  logic            video_present,
  output logic [2*SW-1:0] out_data,
  output logic            out_valid,
  output logic            out_is_vbi
);
  logic [SW-1:0]   lim_sample;
  logic [SW-1:0]   blue_byte;
  logic [2*SW-1:0] blue_word;

  vbi_limit #(.SW(SW)) u_limit (
    .en (limit_en),
    .d  (in_sample),
    .q  (lim_sample)
  );

  vbi_blue_gen #(.SW(SW)) u_blue (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (video_present),
    .adv       (in_valid & ~video_present),
    .blue_byte (blue_byte),
    .blue_word (blue_word)
  );

  vbi_order_core #(.SW(SW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_8b   (mode_8b),
    .order_nat (order_nat),
    .video     (video_present),
    .s_valid   (in_valid),
    .s_data    (lim_sample),
    .s_last    (in_last),
    .blue_byte (blue_byte),
    .blue_word (blue_word),
    .o_data    (out_data),
    .o_valid   (out_valid),
    .o_vbi     (out_is_vbi)
  );
endmodule

// File: rtl/vbi_fmt_chk.sv
module vbi_fmt_chk #(
  parameter int unsigned SW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_8b,
  input logic            limit_en,
  input logic            video_present,
  input logic [2*SW-1:0] out_data,
  input logic            out_valid,
  input logic            out_is_vbi
);
  localparam logic [SW-1:0] HI_CODE = '1;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  assert_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_vbi && $past(limit_en) && $past(mode_8b))
      |-> (out_data[2*SW-1:SW] != '0 && out_data[2*SW-1:SW] != HI_CODE));

  assert_blue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_vbi && $past(mode_8b))
      |-> ((out_data[15:8] == 8'hF0 || out_data[15:8] == 8'h29 ||
            out_data[15:8] == 8'h6E) && out_data[7:0] == 8'h00));

  assert_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_vbi) |-> $past(video_present));

  assert_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode_8b)) |-> (out_data[SW-1:0] == '0));
endmodule

bind vbi_fmt_top vbi_fmt_chk #(.SW(SW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_8b       (mode_8b),
  .limit_en      (limit_en),
  .video_present (video_present),
  .out_data      (out_data),
  .out_valid     (out_valid),
  .out_is_vbi    (out_is_vbi)
);

// File: tb/tb_vbi_fmt_top.sv
module tb_vbi_fmt_top;
  logic        clk, rst_n, in_valid, in_last, mode_8b, order_nat, limit_en, video_present;
  logic [7:0]  in_sample;
  logic [15:0] out_data;
  logic        out_valid, out_is_vbi;

  vbi_fmt_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_last(in_last), .mode_8b(mode_8b), .order_nat(order_nat),
    .limit_en(limit_en), .video_present(video_present),
    .out_data(out_data), .out_valid(out_valid), .out_is_vbi(out_is_vbi)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [16:0] exp_q[$];
  string       tag_q[$];
  logic [1:0]  bph = 2'd0;
  logic [15:0] prev_data = 16'h0;

  function automatic logic [7:0] blue_b(input logic [1:0] p);
    case (p)
      2'd0: return 8'hF0;
      2'd2: return 8'h6E;
      default: return 8'h29;
    endcase
  endfunction

  function automatic logic [7:0] lim(input logic [7:0] v, input bit en);
    if (en && v == 8'h00) return 8'h01;
    if (en && v == 8'hFF) return 8'hFE;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R8 extra strobe", {15'd0, out_is_vbi, out_data}, 32'h0);
        else begin
          logic [16:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_is_vbi, out_data} === e, {t, " R10"}, {15'd0, out_is_vbi, out_data}, {15'd0, e});
        end
      end else if (out_data !== prev_data) begin
        check(1'b0, "R8 data moved without strobe", {16'd0, out_data}, {16'd0, prev_data});
      end
      prev_data = out_data;
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
  endtask

  task automatic run_line(input int n, input bit m8, input bit ord, input bit le,
                          input bit vid, input bit gaps, input int bias);
    logic [7:0] s[$];
    logic [7:0] l[$];
    string tg;
    for (int k = 0; k < n; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < bias) s.push_back(($urandom_range(0, 1) != 0) ? 8'hFF : 8'h00);
      else s.push_back(8'($urandom));
      l.push_back(lim(s[k], le));
    end
    tg = m8 ? (ord ? "R4" : "R3") : (ord ? "R2" : "R1");
    if (le) tg = {tg, "/R5"};
    if (!vid) begin
      for (int k = 0; k < n; k++) begin
        if (m8) exp_q.push_back({1'b0, blue_b(bph), 8'h00});
        else    exp_q.push_back({1'b0, 8'h29, bph[0] ? 8'h6E : 8'hF0});
        tag_q.push_back("R6");
        bph = bph + 2'd1;
      end
    end else begin
      bph = 2'd0;
      if (m8 && ord) begin
        for (int k = 0; k < n; k++) begin exp_q.push_back({1'b1, l[k], 8'h00}); tag_q.push_back(tg); end
      end else begin
        for (int k = 0; k + 1 < n; k += 2) begin
          if (m8) begin
            exp_q.push_back({1'b1, l[k+1], 8'h00}); tag_q.push_back(tg);
            exp_q.push_back({1'b1, l[k], 8'h00});   tag_q.push_back(tg);
          end else begin
            exp_q.push_back(ord ? {1'b1, l[k+1], l[k]} : {1'b1, l[k], l[k+1]}); tag_q.push_back(tg);
          end
        end
        if (n % 2 == 1) begin
          if (m8)       exp_q.push_back({1'b1, l[n-1], 8'h00});
          else if (ord) exp_q.push_back({1'b1, 8'h80, l[n-1]});
          else          exp_q.push_back({1'b1, l[n-1], 8'h80});
          tag_q.push_back({tg, " R7"});
        end
      end
    end
    @(negedge clk);
    mode_8b = m8; order_nat = ord; limit_en = le; video_present = vid;
    idle(2);
    for (int k = 0; k < n; k++) begin
      if (gaps && $urandom_range(0, 9) < 3) idle(int'($urandom_range(1, 2)));
      @(negedge clk);
      in_valid = 1'b1; in_sample = s[k]; in_last = (k == n - 1);
    end
    idle(5);
    check(exp_q.size() == 0, "R8 output count", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd829));
    rst_n = 1'b0; in_valid = 1'b0; in_sample = 8'h00; in_last = 1'b0;
    mode_8b = 1'b0; order_nat = 1'b0; limit_en = 1'b0; video_present = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_data == 16'h0, "R9 reset state", {15'd0, out_valid, out_data}, 32'h0);
    rst_n = 1'b1;
    idle(2);
    // directed corners
    run_line(4, 0, 0, 0, 1, 0, 0);   // R1
    run_line(4, 0, 1, 0, 1, 0, 0);   // R2
    run_line(6, 1, 0, 0, 1, 0, 0);   // R3 back-to-back
    run_line(5, 1, 1, 0, 1, 0, 0);   // R4
    run_line(1, 1, 0, 0, 1, 0, 0);   // R7 single byte
    run_line(3, 1, 0, 0, 1, 0, 0);   // R7 flush behind pending byte
    run_line(3, 0, 0, 0, 1, 0, 0);   // R7 word pad
    run_line(3, 0, 1, 0, 1, 0, 0);   // R7 word pad reversed
    run_line(8, 1, 0, 1, 1, 0, 100); // R5 extremes clamped
    run_line(8, 0, 0, 0, 1, 0, 100); // R5 extremes pass unclamped
    run_line(6, 1, 0, 0, 0, 0, 0);   // R6 byte lane blue
    run_line(3, 1, 1, 0, 0, 1, 0);   // R6 phase continues
    run_line(5, 0, 0, 0, 0, 0, 0);   // R6 word lane blue
    // constrained random
    for (int i = 0; i < 60; i++) begin
      run_line(int'($urandom_range(1, 20)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
               bit'($urandom_range(0, 1)), $urandom_range(0, 3) != 0, bit'($urandom_range(0, 1)), 25);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule